// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface Controller

This block is a cycle-based model of the command front end of a byte-wide flash memory whose map starts with a protected boot region. A host drives chip enable, write enable and output enable, an 18-bit byte address and an 8-bit data bus, all active-low strobes sampled on the rising clock edge. The controller decodes command bytes, runs a two-write byte program sequence through a busy counter, keeps a status byte with sticky error flags, and switches the read path between array contents and that status byte.

The address space is split into five regions: a 16 KB boot region, two 8 KB parameter regions, a 96 KB main region and a 128 KB main region. A strap input mirrors the map so that the boot region sits at either end. A program aimed at the boot region succeeds only while a high-voltage unlock input stays asserted for the whole program interval. The storage is an internal register array indexed by the low address bits. Its depth and the program duration are parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the array holds FFh in every byte, reads return array data, and the status byte reads 80h (ready, no error).
- R2: `rdata` is 00h unless both `ce_n` and `oe_n` are low. Writing FFh selects array reads, where `rdata` is the byte at the low `MEM_AW` address bits.
- R3: Writing 70h selects status reads. After a 40h write, and after the following address/data write, reads return status. Any opcode other than 40h, 50h, 70h or FFh selects array reads and leaves the array unchanged.
- R4: The status byte has bit 7 = ready, bit 4 = program error, bit 3 = programming-voltage error, and all other bits 0. Bit 7 reads 0 for exactly `BUSY_CYCLES` clock cycles after an accepted data write. Bus writes during that time are ignored.
- R5: A completed program stores old AND new data. If the stored value differs from the requested byte, bit 4 is set.
- R6: If `vpp_ok` is low when the data write arrives, bit 3 is set, no busy period starts and the array is unchanged.
- R7: Bits 3 and 4 stay set through all other commands and operations. Only the 50h command clears them, and 50h leaves the read selection as it was.
- R8: While bit 3 or bit 4 is set, a data write after 40h is refused: no busy period, no array change, and reads return status.
- R9: With `boot_top` low, the boot region is byte addresses 00000h–03FFFh. With it high, the map is mirrored and the boot region is 3C000h–3FFFFh. A program into the boot region without `unlock_hv` sets bit 4 and leaves the array unchanged. Programs into other regions do not depend on `unlock_hv`.
- R10: A boot-region program whose `unlock_hv` drops during any cycle of the busy interval fails as in R9, even if the input returns high before completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low, one write per sampled cycle |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Command or program data byte |
| boot_top | input | 1 | 1 places the boot region at the top of the map |
| unlock_hv | input | 1 | High-voltage qualified unlock for boot-region programs |
| vpp_ok | input | 1 | Programming voltage in range, sampled at program start |
| rdata | output | 8 | Array byte or status byte |

## Verification
A wrong read-selection flag shows up on the very next enabled read, because array data and the status byte rarely match. A wrong busy count changes how many consecutive reads return a cleared bit 7. That count is compared exactly, so an early or late finish is caught within one busy interval. A lost or stray error flag appears in the status byte read right after the operation. Because the flags are sticky, it also causes a refused program at the next attempt, which then shows up as an array byte that stayed at its old value.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] byte_t;

  localparam byte_t OP_READ_ARRAY  = 8'hFF;
  localparam byte_t OP_PROG_SETUP  = 8'h40;
  localparam byte_t OP_CLR_STATUS  = 8'h50;
  localparam byte_t OP_READ_STATUS = 8'h70;

  typedef enum logic [2:0] {
    BLK_BOOT, BLK_PARAM_A, BLK_PARAM_B, BLK_MAIN_SMALL, BLK_MAIN_LARGE
  } blk_e;

  // Cells can only move from 1 to 0.
  function automatic byte_t prog_merge(byte_t old_v, byte_t new_v);
    return old_v & new_v;
  endfunction

  function automatic byte_t status_pack(logic ready, logic perr, logic verr);
    return {ready, 2'b00, perr, verr, 3'b000};
  endfunction
endpackage

// File: rtl/fcc_block_map.sv
module fcc_block_map
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_top,
  output logic              is_boot
);
  localparam logic [ADDR_W:0] SPAN    = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] END_BT  = SPAN >> 4;
  localparam logic [ADDR_W:0] END_PA  = END_BT + (SPAN >> 5);
  localparam logic [ADDR_W:0] END_PB  = END_PA + (SPAN >> 5);
  localparam logic [ADDR_W:0] END_MS  = SPAN >> 1;

  // Mirroring the address turns the top-boot map into the bottom-boot map.
  logic [ADDR_W:0] off;
  blk_e            blk;

  assign off = {1'b0, (boot_top ? ~addr : addr)};

  always_comb begin
    if (off < END_BT)      blk = BLK_BOOT;
    else if (off < END_PA) blk = BLK_PARAM_A;
    else if (off < END_PB) blk = BLK_PARAM_B;
    else if (off < END_MS) blk = BLK_MAIN_SMALL;
    else                   blk = BLK_MAIN_LARGE;
  end

  assign is_boot = (blk == BLK_BOOT);
endmodule

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/fcc_array.sv
module fcc_array
  import fcc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output byte_t         rd_data,
  input  logic [AW-1:0] pg_addr,
  output byte_t         pg_old,
  input  logic          we,
  input  byte_t         wval
);
  localparam int DEPTH = 1 << AW;
  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[pg_addr] <= wval;
    end
  end

  assign rd_data = mem[rd_addr];
  assign pg_old  = mem[pg_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int MEM_AW      = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              boot_top,
  input  logic              unlock_hv,
  input  logic              vpp_ok,
  output logic [7:0]        rdata
);
  // Named events, also observed by the bound checker.
  logic wr_evt, rd_en, cmd_evt, prog_req, prog_go, vpp_fail, clr_evt;
  logic busy, done_evt, err_any, lock_bad, mem_we, perr_set, in_boot;
  logic setup_q, rd_stat_q, sr_perr_q, sr_verr_q, lock_fail_q, tgt_boot_q;
  logic [MEM_AW-1:0] tgt_addr_q;
  byte_t tgt_data_q, arr_rd, arr_old, merged, status;

  assign wr_evt   = !ce_n && !we_n;
  assign rd_en    = !ce_n && !oe_n;
  assign cmd_evt  = wr_evt && !busy && !setup_q;
  assign prog_req = wr_evt && !busy && setup_q;
  assign err_any  = sr_perr_q || sr_verr_q;
  assign prog_go  = prog_req && !err_any && vpp_ok;
  assign vpp_fail = prog_req && !err_any && !vpp_ok;
  assign clr_evt  = cmd_evt && (wdata == OP_CLR_STATUS);

  fcc_block_map #(.ADDR_W(ADDR_W)) u_map (
    .addr(addr), .boot_top(boot_top), .is_boot(in_boot)
  );

  fcc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy), .done(done_evt)
  );

  fcc_array #(.AW(MEM_AW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(addr[MEM_AW-1:0]), .rd_data(arr_rd),
    .pg_addr(tgt_addr_q), .pg_old(arr_old),
    .we(mem_we), .wval(merged)
  );

  // Boot target loses its unlock in any cycle from start to completion.
  assign lock_bad = lock_fail_q || (tgt_boot_q && !unlock_hv);
  assign merged   = prog_merge(arr_old, tgt_data_q);
  assign mem_we   = done_evt && !lock_bad;
  assign perr_set = done_evt && (lock_bad || (merged != tgt_data_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr_q  <= '0;
      tgt_data_q  <= '0;
      tgt_boot_q  <= 1'b0;
      lock_fail_q <= 1'b0;
    end else if (prog_go) begin
      tgt_addr_q  <= addr[MEM_AW-1:0];
      tgt_data_q  <= wdata;
      tgt_boot_q  <= in_boot;
      lock_fail_q <= in_boot && !unlock_hv;
    end else if (busy && tgt_boot_q && !unlock_hv) begin
      lock_fail_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_perr_q <= 1'b0;
      sr_verr_q <= 1'b0;
    end else begin
      if (clr_evt)       sr_perr_q <= 1'b0;
      else if (perr_set) sr_perr_q <= 1'b1;
      if (clr_evt)       sr_verr_q <= 1'b0;
      else if (vpp_fail) sr_verr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q   <= 1'b0;
      rd_stat_q <= 1'b0;
    end else if (prog_req) begin
      setup_q   <= 1'b0;
      rd_stat_q <= 1'b1;
    end else if (cmd_evt) begin
      unique case (wdata)
        OP_PROG_SETUP:  begin setup_q <= 1'b1; rd_stat_q <= 1'b1; end
        OP_READ_STATUS: rd_stat_q <= 1'b1;
        OP_CLR_STATUS:  rd_stat_q <= rd_stat_q;
        default:        rd_stat_q <= 1'b0;
      endcase
    end
  end

  assign status = status_pack(!busy, sr_perr_q, sr_verr_q);
  assign rdata  = !rd_en ? 8'h00 : (rd_stat_q ? status : arr_rd);
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int BUSY_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done_evt,
  input logic       prog_req,
  input logic       err_any,
  input logic       vpp_ok,
  input logic       lock_bad,
  input logic       sr_perr_q,
  input logic       sr_verr_q,
  input logic       clr_evt,
  input logic       rd_en,
  input logic       rd_stat_q,
  input logic [7:0] rdata
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 16'(BUSY_CYCLES)));

  p_ready_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_stat_q && busy) |-> !rdata[7]);

  p_vpp_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !err_any && !vpp_ok) |=> (sr_verr_q && !busy));

  p_perr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_perr_q && !clr_evt) |=> sr_perr_q);

  p_verr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_verr_q && !clr_evt) |=> sr_verr_q);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (!sr_perr_q && !sr_verr_q));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && err_any) |=> !busy);

  p_boot_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && lock_bad) |=> sr_perr_q);
endmodule

bind flash_cmd_ctrl fcc_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_fcc_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_evt(done_evt),
  .prog_req(prog_req), .err_any(err_any), .vpp_ok(vpp_ok),
  .lock_bad(lock_bad), .sr_perr_q(sr_perr_q), .sr_verr_q(sr_verr_q),
  .clr_evt(clr_evt), .rd_en(rd_en), .rd_stat_q(rd_stat_q), .rdata(rdata)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int BUSY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic boot_top = 1'b0, unlock_hv = 1'b0, vpp_ok = 1'b1;
  logic [7:0] rdata;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(18), .MEM_AW(8), .BUSY_CYCLES(BUSY)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .boot_top(boot_top), .unlock_hv(unlock_hv),
    .vpp_ok(vpp_ok), .rdata(rdata)
  );

  typedef struct packed {
    logic        top;
    logic [17:0] a;
    logic [7:0]  d;
    logic        ul;
    logic        vp;
    logic [7:0]  st;
    logic [7:0]  mem;
  } vec_t;

  // Expected status and stored byte, derived from R5, R6 and R9.
  localparam vec_t VECS [14] = '{
    '{1'b0, 18'h08005, 8'hA5, 1'b0, 1'b1, 8'h80, 8'hA5},  // R5 main
    '{1'b0, 18'h08005, 8'h5A, 1'b0, 1'b1, 8'h90, 8'h00},  // R5 mismatch
    '{1'b0, 18'h00010, 8'h12, 1'b0, 1'b1, 8'h90, 8'hFF},  // R9 bottom boot locked
    '{1'b0, 18'h00010, 8'h12, 1'b1, 1'b1, 8'h80, 8'h12},  // R10 unlock held
    '{1'b1, 18'h00020, 8'h33, 1'b0, 1'b1, 8'h80, 8'h33},  // R9 low end is main when top
    '{1'b1, 18'h3C030, 8'h44, 1'b0, 1'b1, 8'h90, 8'hFF},  // R9 top boot locked
    '{1'b1, 18'h3FFFF, 8'h0F, 1'b1, 1'b1, 8'h80, 8'h0F},  // R9 top boot unlocked
    '{1'b0, 18'h3FFFF, 8'h07, 1'b0, 1'b1, 8'h80, 8'h07},  // R9 top end is main when bottom
    '{1'b0, 18'h04001, 8'h66, 1'b0, 1'b0, 8'h88, 8'hFF},  // R6 vpp low
    '{1'b1, 18'h3BFFE, 8'h81, 1'b0, 1'b1, 8'h80, 8'h81},  // R9 param below top boot
    '{1'b0, 18'h03FFF, 8'h00, 1'b0, 1'b1, 8'h90, 8'h07},  // R9 last boot byte
    '{1'b0, 18'h04000, 8'hC3, 1'b0, 1'b1, 8'h80, 8'hC3},  // R9 first param byte
    '{1'b1, 18'h3BF40, 8'h11, 1'b0, 1'b1, 8'h80, 8'h11},  // R9 param, top map
    '{1'b1, 18'h3C000, 8'h22, 1'b0, 1'b1, 8'h90, 8'hC3}   // R9 first top boot byte
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(posedge clk);
    #1;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [17:0] a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #2;
    d = rdata;
    #2;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // Reads status until ready; returns the count of busy samples seen.
  task automatic wait_ready(output int nbusy, output logic [7:0] st);
    nbusy = 0;
    for (int k = 0; k < 40; k++) begin
      bus_rd(18'h0, st);
      if (st[7]) break;
      nbusy++;
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_rd(18'h12345, v); check("R1 array erased", v, 8'hFF);
    bus_wr(18'h0, 8'h70);
    bus_rd(18'h0, v);     check("R1 status after reset", v, 8'h80);

    // R2: output gating
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #2;
    check("R2 oe_n high gives 00", rdata, 8'h00);
    ce_n = 1'b1;
    bus_wr(18'h0, 8'hFF);
    bus_rd(18'h00001, v); check("R2 array read after FFh", v, 8'hFF);

    // Table of program vectors
    foreach (VECS[i]) begin
      @(negedge clk);
      boot_top = VECS[i].top; unlock_hv = VECS[i].ul; vpp_ok = VECS[i].vp;
      bus_wr(18'h0, 8'h50);
      bus_wr(18'h0, 8'h40);
      bus_wr(VECS[i].a, VECS[i].d);
      wait_ready(nb, v);
      check($sformatf("R5/R6/R9 status vec %0d", i), v, VECS[i].st);
      bus_wr(18'h0, 8'hFF);
      bus_rd(VECS[i].a, v);
      check($sformatf("R5/R6/R9 stored byte vec %0d", i), v, VECS[i].mem);
    end
    @(negedge clk); boot_top = 1'b0; unlock_hv = 1'b0; vpp_ok = 1'b1;

    // R4: busy length, status layout, writes ignored while busy
    bus_wr(18'h0, 8'h50);
    bus_wr(18'h0, 8'h40);
    bus_wr(18'h08060, 8'h3C);
    bus_rd(18'h0, v); check("R4 bit7 low while busy", v, 8'h00);
    bus_wr(18'h0, 8'hFF);  // lands inside the busy window
    wait_ready(nb, v);
    check("R4 busy sample count", 8'(nb + 2), 8'(BUSY));
    check("R4 still status after write while busy", v, 8'h80);
    check("R3 status mode after program", v, 8'h80);
    bus_wr(18'h0, 8'hFF);
    bus_rd(18'h08060, v); check("R5 programmed byte", v, 8'h3C);

    // R3: status mode then unknown opcode returns to array
    bus_wr(18'h0, 8'h70);
    bus_rd(18'h08060, v); check("R3 70h status", v, 8'h80);
    bus_wr(18'h08060, 8'h20);
    bus_rd(18'h08060, v); check("R3 unknown opcode to array", v, 8'h3C);

    // R7/R8: sticky error and refused program
    bus_wr(18'h0, 8'h40);
    bus_wr(18'h00070, 8'h00);
    wait_ready(nb, v); check("R9 boot lock error", v, 8'h90);
    bus_wr(18'h0, 8'hFF);
    bus_wr(18'h0, 8'h70);
    bus_rd(18'h0, v); check("R7 error survives mode commands", v, 8'h90);
    bus_wr(18'h0, 8'h40);
    bus_wr(18'h08070, 8'h00);
    bus_rd(18'h0, v); check("R8 refused program not busy", v, 8'h90);
    bus_wr(18'h0, 8'h50);
    bus_rd(18'h0, v); check("R7 50h clears, keeps status mode", v, 8'h80);
    bus_wr(18'h0, 8'hFF);
    bus_rd(18'h08070, v); check("R8 refused program left array", v, 8'hFF);

    // R10: unlock dropped mid-interval
    @(negedge clk); unlock_hv = 1'b1;
    bus_wr(18'h0, 8'h40);
    bus_wr(18'h00050, 8'h05);
    @(negedge clk); unlock_hv = 1'b0;
    @(negedge clk); unlock_hv = 1'b1;
    wait_ready(nb, v); check("R10 unlock drop fails", v, 8'h90);
    bus_wr(18'h0, 8'hFF);
    bus_rd(18'h00050, v); check("R10 boot byte unchanged", v, 8'hFF);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule